// File: doc/BRIEF.md
# Flash Word Write-Rule Tracker

This block is a behavioural model of one erasable page of 32-bit flash words. It stores every word and accepts three commands: erase the whole page, program a word, and read a word back. A program can only clear bits, so the stored word becomes the old value ANDed with the new data. A bit programmed with 1 keeps its value.

While it programs, the block keeps count of how often each bit has received a 0, how often each word has been written and how often the page has been written since the last erase. The write that takes any of these counts past its limit leaves the word it targets with undefined contents. The block marks that word undefined and raises a violation flag that stays set until the next erase. Readback returns the stored word together with its undefined marker one clock after the read strobe.

This makes it a checker for data-logging code that packs several small updates into one word between erases. For example, it can confirm that a log which fills a word four bits at a time, eight times, stays inside the rules.

Top module: `flash_wordlog_tracker`

## Requirements
- R1: An erase sets every word to 0xFFFFFFFF and clears every undefined marker, the violation flag and all write counts. When an erase and a write arrive in the same cycle, the erase wins and the write is dropped.
- R2: A program with an in-range index leaves the target word equal to its previous value AND the written data. Bits written 1 are unchanged.
- R3: Each bit may receive a 0 at most MAX_BIT_ZEROS (default 2) times between erases, whatever its current value. A write that gives any bit its next 0 marks the target word undefined.
- R4: A word may be written at most MAX_WORD_WRITES (default 8) times between erases. The next write to it marks that word undefined.
- R5: The page may take at most MAX_PAGE_WRITES (default 1024) in-range writes between erases. The next in-range write marks its target word undefined.
- R6: A violation sets viol_o on the clock edge of the offending write. viol_o stays 1 until an erase or reset. Only the word targeted by the offending write is marked undefined.
- R7: Eight writes that each clear new bits in one nibble of a word, from the lowest nibble upward, cause no violation. The word ends up holding all eight nibbles.
- R8: A write whose index is NUM_WORDS or more changes no word and no count. It raises idx_err_o for exactly the one cycle after its clock edge.
- R9: A read strobe returns rd_data_o and rd_undef_o, with rd_valid_o high, in the cycle after the strobe. rd_valid_o is low otherwise. An out-of-range read index returns 0xFFFFFFFF with rd_undef_o = 1.
- R10: After reset, the outputs are low and the page is in the same state as after an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase_i | input | 1 | Page erase command |
| wr_i | input | 1 | Word program command |
| wr_idx_i | input | IDX_W | Word index for program |
| wr_data_i | input | WORD_W | Program data (0 bits clear) |
| rd_i | input | 1 | Read strobe |
| rd_idx_i | input | IDX_W | Word index for read |
| rd_data_o | output | WORD_W | Registered read data |
| rd_undef_o | output | 1 | Read word is undefined |
| rd_valid_o | output | 1 | Read result valid this cycle |
| viol_o | output | 1 | Sticky limit-violation flag |
| idx_err_o | output | 1 | One-cycle out-of-range write pulse |

IDX_W is $clog2(NUM_WORDS)+1, so an index can name a word past the page.

## Verification
The page-count limit is the hardest case to reach. With the default 16 words, every word hits its own limit of eight writes long before the page reaches 1024 writes, so the page limit can never fire first. The bench therefore builds the tracker with a page limit of 20. It spreads 20 all-ones writes over three words, each below its own word limit. It then sends the 21st write to a fresh fourth word, so that word can only be marked undefined by the page count.

// File: rtl/fwt_pkg.sv
// Package: shared defaults for the flash word write-rule tracker.
// Assumes nothing beyond being compiled before the modules that use it.
package fwt_pkg;
    localparam int DEF_WORD_W      = 32;
    localparam int DEF_NUM_WORDS   = 16;
    localparam int DEF_BIT_ZEROS   = 2;
    localparam int DEF_WORD_WRITES = 8;
    localparam int DEF_PAGE_WRITES = 1024;
endpackage

// File: rtl/fwt_page_tally.sv
// Module: counts in-range writes to the page since the last erase.
// It flags the write that goes past the page limit.
// Assumes wr_i is already gated by index range and erase priority.
module fwt_page_tally #(
    parameter int MAX_PAGE_WRITES = fwt_pkg::DEF_PAGE_WRITES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic wr_i,
    output logic over_o
);
    localparam int PC_W = $clog2(MAX_PAGE_WRITES + 2);

    logic [PC_W-1:0] pcnt;

    // The current write is over the limit once the count has reached it.
    assign over_o = wr_i && (pcnt >= PC_W'(MAX_PAGE_WRITES));

    // Saturating page write counter, cleared by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            pcnt <= '0;
        else if (wr_i && (pcnt != PC_W'(MAX_PAGE_WRITES + 1)))
            pcnt <= pcnt + 1'b1;
    end

    assert_page_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PC_W'(MAX_PAGE_WRITES + 1));
    assert_page_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pcnt == '0));
endmodule

// File: rtl/fwt_word_slot.sv
// Module: one flash word. It holds the stored data (AND on program), the
// per-bit zero-write counters, the word write counter and the undefined marker.
// Assumes wr_i is only high for an in-range write that no erase overrides.
module fwt_word_slot #(
    parameter int WORD_W          = fwt_pkg::DEF_WORD_W,
    parameter int MAX_BIT_ZEROS   = fwt_pkg::DEF_BIT_ZEROS,
    parameter int MAX_WORD_WRITES = fwt_pkg::DEF_WORD_WRITES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              page_over_i,
    output logic [WORD_W-1:0] data_o,
    output logic              undef_o,
    output logic              viol_o
);
    localparam int ZC_W = $clog2(MAX_BIT_ZEROS + 2);
    localparam int WC_W = $clog2(MAX_WORD_WRITES + 2);

    logic [WORD_W-1:0] bit_over;
    logic [WC_W-1:0]   wcnt;
    logic              word_over;

    genvar b;
    generate
        for (b = 0; b < WORD_W; b++) begin : g_bit
            logic [ZC_W-1:0] zcnt;
            // This bit is over its limit if it gets another 0 after reaching the limit.
            assign bit_over[b] = !data_i[b] && (zcnt >= ZC_W'(MAX_BIT_ZEROS));
            // Saturating count of zeros programmed into this bit.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    zcnt <= '0;
                else if (wr_i && !data_i[b] && (zcnt != ZC_W'(MAX_BIT_ZEROS + 1)))
                    zcnt <= zcnt + 1'b1;
            end
        end
    endgenerate

    assign word_over = (wcnt >= WC_W'(MAX_WORD_WRITES));
    assign viol_o    = wr_i && ((|bit_over) || word_over || page_over_i);

    // Saturating word write counter, cleared by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            wcnt <= '0;
        else if (wr_i && (wcnt != WC_W'(MAX_WORD_WRITES + 1)))
            wcnt <= wcnt + 1'b1;
    end

    // Stored data: erase sets it to all ones, a program clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            data_o <= '1;
        else if (wr_i)
            data_o <= data_o & data_i;
    end

    // Undefined marker: set by a violating write, cleared by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            undef_o <= 1'b0;
        else if (viol_o)
            undef_o <= 1'b1;
    end

    assert_erase_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((data_o == '1) && !undef_o));
    assert_and_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> ((data_o & ~$past(data_i)) == '0));
    assert_word_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i && (wcnt >= WC_W'(MAX_WORD_WRITES))) |=> undef_o);
    assert_no_write_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i) |=> $stable(data_o));
endmodule

// File: rtl/flash_wordlog_tracker.sv
// Module: top of the flash word write-rule tracker. It decodes the write
// index, fans commands out to the word slots and the page tally, keeps the
// sticky violation flag and registers read results.
// Assumes NUM_WORDS is a power of two of at least 2. Erase beats a same-cycle write.
module flash_wordlog_tracker #(
    parameter int WORD_W          = fwt_pkg::DEF_WORD_W,
    parameter int NUM_WORDS       = fwt_pkg::DEF_NUM_WORDS,
    parameter int MAX_BIT_ZEROS   = fwt_pkg::DEF_BIT_ZEROS,
    parameter int MAX_WORD_WRITES = fwt_pkg::DEF_WORD_WRITES,
    parameter int MAX_PAGE_WRITES = fwt_pkg::DEF_PAGE_WRITES,
    localparam int SEL_W          = $clog2(NUM_WORDS),
    localparam int IDX_W          = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_undef_o,
    output logic              rd_valid_o,
    output logic              viol_o,
    output logic              idx_err_o
);
    logic                 wr_in_range, rd_in_range;
    logic                 wr_ok, wr_bad;
    logic                 page_over;
    logic [NUM_WORDS-1:0] slot_wr, slot_viol, slot_undef;
    logic [WORD_W-1:0]    slot_data [NUM_WORDS];

    assign wr_in_range = (wr_idx_i < IDX_W'(NUM_WORDS));
    assign rd_in_range = (rd_idx_i < IDX_W'(NUM_WORDS));
    assign wr_ok       = wr_i && !erase_i && wr_in_range;
    assign wr_bad      = wr_i && !erase_i && !wr_in_range;

    fwt_page_tally #(.MAX_PAGE_WRITES(MAX_PAGE_WRITES)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (erase_i),
        .wr_i   (wr_ok),
        .over_o (page_over)
    );

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_slot
            assign slot_wr[w] = wr_ok && (wr_idx_i[SEL_W-1:0] == SEL_W'(w));
            fwt_word_slot #(
                .WORD_W          (WORD_W),
                .MAX_BIT_ZEROS   (MAX_BIT_ZEROS),
                .MAX_WORD_WRITES (MAX_WORD_WRITES)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .clr_i       (erase_i),
                .wr_i        (slot_wr[w]),
                .data_i      (wr_data_i),
                .page_over_i (page_over),
                .data_o      (slot_data[w]),
                .undef_o     (slot_undef[w]),
                .viol_o      (slot_viol[w])
            );
        end
    endgenerate

    // Sticky violation flag: set by any violating write, cleared by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i)
            viol_o <= 1'b0;
        else if (|slot_viol)
            viol_o <= 1'b1;
    end

    // Out-of-range write pulse, high for the one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_err_o <= 1'b0;
        else
            idx_err_o <= wr_bad;
    end

    // Registered readback with a one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
            rd_undef_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_i;
            if (rd_i) begin
                if (rd_in_range) begin
                    rd_data_o  <= slot_data[rd_idx_i[SEL_W-1:0]];
                    rd_undef_o <= slot_undef[rd_idx_i[SEL_W-1:0]];
                end else begin
                    rd_data_o  <= '1;
                    rd_undef_o <= 1'b1;
                end
            end
        end
    end

    assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_wr));
    assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !erase_i) |=> viol_o);
    assert_idx_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> idx_err_o);
    assert_idx_err_only_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bad |=> !idx_err_o);
    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rd_valid_o);
    assert_erase_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> !viol_o);
endmodule

// File: tb/flash_wordlog_tracker_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module flash_wordlog_tracker_test;
    localparam int WW = 32;
    localparam int NW = 16;
    localparam int PL = 20;
    localparam int IW = $clog2(NW) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0, rd_idx_i = '0;
    logic [WW-1:0] wr_data_i = '0;
    logic [WW-1:0] rd_data_o;
    logic          rd_undef_o, rd_valid_o, viol_o, idx_err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_wordlog_tracker #(.NUM_WORDS(NW), .MAX_PAGE_WRITES(PL)) uut (
        .clk(clk), .rst_n(rst_n), .erase_i(erase_i), .wr_i(wr_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .rd_i(rd_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .rd_undef_o(rd_undef_o),
        .rd_valid_o(rd_valid_o), .viol_o(viol_o), .idx_err_o(idx_err_o)
    );

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_erase();
        @(negedge clk); erase_i = 1'b1;
        @(negedge clk); erase_i = 1'b0;
    endtask

    task automatic do_write(input int idx, input logic [WW-1:0] d);
        @(negedge clk); wr_i = 1'b1; wr_idx_i = IW'(idx); wr_data_i = d;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic do_read(input int idx, output logic [WW-1:0] d, output logic u);
        @(negedge clk); rd_i = 1'b1; rd_idx_i = IW'(idx);
        @(negedge clk); rd_i = 1'b0;
        check("R9 valid", WW'(rd_valid_o), 1);
        d = rd_data_o; u = rd_undef_o;
    endtask

    task automatic t_reset();
        logic [WW-1:0] d; logic u;
        check("R10 viol", WW'(viol_o), 0);
        check("R10 idx_err", WW'(idx_err_o), 0);
        check("R10 valid", WW'(rd_valid_o), 0);
        do_read(0, d, u);
        check("R10 data", d, 32'hFFFFFFFF);
        check("R10 undef", WW'(u), 0);
    endtask

    task automatic t_and();
        logic [WW-1:0] d; logic u;
        do_erase();
        do_write(5, 32'hF0F0F0F0);
        do_write(5, 32'hFF00FF00);
        do_read(5, d, u);
        check("R2 and", d, 32'hF000F000);
        do_write(5, 32'hFFFFFFFF);
        do_read(5, d, u);
        check("R2 ones keep", d, 32'hF000F000);
        check("R2 no viol", WW'(viol_o), 0);
    endtask

    task automatic t_log();
        logic [WW-1:0] d; logic u;
        do_erase();
        for (int k = 0; k < 8; k++) do_write(3, ~(32'h5 << (4 * k)));
        do_read(3, d, u);
        check("R7 data", d, 32'hAAAAAAAA);
        check("R7 undef", WW'(u), 0);
        check("R7 viol", WW'(viol_o), 0);
    endtask

    task automatic t_bit_limit();
        logic [WW-1:0] d; logic u;
        do_erase();
        do_write(1, 32'hFFFFFFFE);
        do_write(1, 32'hFFFFFFFE);
        do_read(1, d, u);
        check("R3 two zeros ok", WW'(u), 0);
        check("R3 no viol yet", WW'(viol_o), 0);
        do_write(1, 32'hFFFFFFFE);
        check("R3 viol", WW'(viol_o), 1);
        do_read(1, d, u);
        check("R3 undef", WW'(u), 1);
        do_read(0, d, u);
        check("R6 other word clean", WW'(u), 0);
    endtask

    task automatic t_word_limit();
        logic [WW-1:0] d; logic u;
        do_erase();
        for (int k = 0; k < 8; k++) do_write(2, 32'hFFFFFFFF);
        do_read(2, d, u);
        check("R4 eight ok", WW'(u), 0);
        check("R4 no viol", WW'(viol_o), 0);
        do_write(2, 32'hFFFFFFFF);
        do_read(2, d, u);
        check("R4 undef", WW'(u), 1);
        do_write(6, 32'hFFFFFFFF);
        check("R6 sticky", WW'(viol_o), 1);
        do_erase();
        check("R1 viol cleared", WW'(viol_o), 0);
        do_read(2, d, u);
        check("R1 undef cleared", WW'(u), 0);
        check("R1 data ones", d, 32'hFFFFFFFF);
    endtask

    task automatic t_page_limit();
        logic [WW-1:0] d; logic u;
        do_erase();
        for (int k = 0; k < 8; k++) do_write(0, 32'hFFFFFFFF);
        for (int k = 0; k < 8; k++) do_write(1, 32'hFFFFFFFF);
        for (int k = 0; k < 4; k++) do_write(2, 32'hFFFFFFFF);
        check("R5 at limit no viol", WW'(viol_o), 0);
        do_write(3, 32'hFFFFFFFF);
        check("R5 viol", WW'(viol_o), 1);
        do_read(3, d, u);
        check("R5 undef", WW'(u), 1);
        do_read(2, d, u);
        check("R6 word2 clean", WW'(u), 0);
    endtask

    task automatic t_bad_index();
        logic [WW-1:0] d; logic u;
        do_erase();
        @(negedge clk); wr_i = 1'b1; wr_idx_i = IW'(NW); wr_data_i = '0;
        @(negedge clk); wr_i = 1'b0;
        check("R8 pulse", WW'(idx_err_o), 1);
        @(negedge clk);
        check("R8 pulse ends", WW'(idx_err_o), 0);
        do_read(0, d, u);
        check("R8 word0 unchanged", d, 32'hFFFFFFFF);
        for (int k = 0; k < 8; k++) do_write(0, 32'hFFFFFFFF);
        check("R8 not counted", WW'(viol_o), 0);
        do_read(NW, d, u);
        check("R9 oob data", d, 32'hFFFFFFFF);
        check("R9 oob undef", WW'(u), 1);
        @(negedge clk);
        check("R9 valid drops", WW'(rd_valid_o), 0);
    endtask

    task automatic t_erase_priority();
        logic [WW-1:0] d; logic u;
        do_erase();
        @(negedge clk); erase_i = 1'b1; wr_i = 1'b1; wr_idx_i = IW'(4); wr_data_i = '0;
        @(negedge clk); erase_i = 1'b0; wr_i = 1'b0;
        check("R1 no idx err", WW'(idx_err_o), 0);
        do_read(4, d, u);
        check("R1 erase wins", d, 32'hFFFFFFFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_and();
        t_log();
        t_bit_limit();
        t_word_limit();
        t_page_limit();
        t_bad_index();
        t_erase_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule